// File: doc/BRIEF.md
# Burst Byte-Exchange Sequencer

This block runs a burst of full-duplex byte exchanges for a serial peripheral controller. Software or a register front end fills a transmit queue and raises a start request. The sequencer then takes bytes from that queue one at a time, in arrival order. It passes each byte to an external shift engine and collects the byte the engine returns. The returned byte either goes into a receive queue or is thrown away.

A leading-dummy mode lets the first few returned bytes be skipped. This covers command and address phases whose replies carry no data. An optional exchange limit can end the burst while transmit bytes are still queued. The burst also ends when the transmit queue runs dry. Either way the sequencer gives a one-cycle completion pulse, which the register front end uses to raise its transfer-complete status and clear its exchange request.

Both byte queues sit inside the block. The shift engine, the clock polarity and phase, and all software-visible registers are outside it.

Top module: `spi_burst_sequencer`

## Requirements
- R1: After reset, `busy` and `complete` are low, `tx_empty` and `rx_empty` are high, and `tx_full` and `rx_full` are low.
- R2: Transmit bytes reach `sh_txd` in the order they were written. Each byte is announced by a one-cycle `sh_start`. No new `sh_start` is issued until `sh_done` has answered the previous one.
- R3: With `skip_mode` low, every byte returned on `sh_rxd` is stored in the receive queue, in exchange order.
- R4: With `skip_mode` high at start, the bytes returned by the first `skip_len` exchanges are discarded and later ones are stored. A `skip_len` larger than the burst discards every returned byte.
- R5: A nonzero `burst_len` ends the burst after exactly that many exchanges, even if transmit bytes remain. The remaining bytes stay queued for a later burst, in order.
- R6: The burst ends when the transmit queue is empty at the point the next byte would be fetched. A start with an empty transmit queue completes with no exchange at all.
- R7: A `burst_len` of zero places no limit on the exchange count, so the burst runs until the transmit queue is empty.
- R8: A returned byte that is due to be stored while the receive queue is full is discarded. That exchange pulses `rx_drop` for one cycle, and `rx_full` stays high.
- R9: `busy` rises the cycle after an accepted start and stays high through the single cycle in which `complete` pulses. A start that arrives while `busy` is high is ignored.
- R10: `skip_mode`, `skip_len` and `burst_len` are captured when the start is accepted. Changing them during a burst does not alter that burst.
- R11: A transmit write while `tx_full` is high is ignored. The transmit queue keeps its first `FIFO_DEPTH` bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_wr | input | 1 | Write one byte into the transmit queue |
| tx_wdata | input | 8 | Byte to write into the transmit queue |
| tx_full | output | 1 | Transmit queue holds FIFO_DEPTH bytes |
| tx_empty | output | 1 | Transmit queue holds no byte |
| rx_rd | input | 1 | Remove the head byte of the receive queue |
| rx_rdata | output | 8 | Head byte of the receive queue (show-ahead) |
| rx_empty | output | 1 | Receive queue holds no byte |
| rx_full | output | 1 | Receive queue holds FIFO_DEPTH bytes |
| start | input | 1 | Request a burst; honoured only while idle |
| skip_mode | input | 1 | Leading-dummy mode, captured at start |
| burst_len | input | 24 | Exchange limit, 0 means no limit; captured at start |
| skip_len | input | 24 | Number of leading returned bytes to drop; captured at start |
| sh_start | output | 1 | One-cycle request to the shift engine to exchange `sh_txd` |
| sh_txd | output | 8 | Byte to be shifted out, held stable for the whole exchange |
| sh_done | input | 1 | One-cycle pulse from the engine, no earlier than the cycle after `sh_start` |
| sh_rxd | input | 8 | Byte shifted in, valid while `sh_done` is high |
| rx_drop | output | 1 | A returned byte was discarded because the receive queue was full |
| busy | output | 1 | A burst is in progress |
| complete | output | 1 | One-cycle pulse when a burst ends |

## Verification
The sequencer can write a returned byte into the receive queue in the same cycle that the consumer removes the head byte. A monitor that drains the receive queue whenever it is non-empty, while bursts run with engine latencies that vary from one to three cycles, makes these cycles collide repeatedly. The scoreboard judges the result by order and count: every byte must arrive exactly once, in exchange order, and nothing may be left over. The second collision is a start request landing while a burst is already running, and with it a change to the burst settings in mid-flight. The bench forces this by raising start, changing the settings and raising start again one cycle later. It then requires exactly one completion and the exchange count and stored bytes of the first request only.

// File: rtl/burstseq_pkg.sv
package burstseq_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_ISSUE,
    SQ_WAIT,
    SQ_FINISH
  } seq_state_e;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [LW-1:0] level_next(input logic [LW-1:0] l,
                                               input logic up, input logic dn);
    logic [LW-1:0] r;
    r = l;
    if (up && !dn) r = l + 1'b1;
    if (dn && !up) r = l - 1'b1;
    return r;
  endfunction

  assign full    = (level == FULL_LVL);
  assign empty   = (level == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_wr) wr_ptr <= ptr_next(wr_ptr);
      if (do_rd) rd_ptr <= ptr_next(rd_ptr);
      level <= level_next(level, do_wr, do_rd);
    end
  end

  // R11 / R8: a write on a full queue without a read leaves the fill unchanged
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (level == $past(level)));

  // R2: reads are only issued on a non-empty queue
  assert_read_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);

endmodule

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
  import burstseq_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              skip_mode,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  skip_len,
  input  logic              tx_empty,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              sh_start,
  output logic [BYTE_W-1:0] sh_txd,
  input  logic              sh_done,
  input  logic [BYTE_W-1:0] sh_rxd,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_wdata,
  output logic              rx_drop,
  output logic              busy,
  output logic              complete
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  seq_state_e        state;
  logic [CNT_W-1:0]  burst_left, skip_left;
  logic              lim_q;
  logic [BYTE_W-1:0] txd_q;
  logic              outstanding;

  // named internal events
  logic ex_done;
  logic skipping;
  logic last_xchg;
  logic fetch_dry;

  function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  function automatic logic burst_ends(input logic lim, input logic [CNT_W-1:0] left);
    return lim && (left == ONE);
  endfunction

  assign ex_done   = (state == SQ_WAIT) && sh_done;
  assign skipping  = (skip_left != '0);
  assign last_xchg = burst_ends(lim_q, burst_left);
  assign fetch_dry = (state == SQ_FETCH) && tx_empty;

  assign tx_pop   = (state == SQ_FETCH) && !tx_empty;
  assign sh_start = (state == SQ_ISSUE);
  assign sh_txd   = txd_q;
  assign rx_wdata = sh_rxd;
  assign rx_push  = ex_done && !skipping && !rx_full;
  assign rx_drop  = ex_done && !skipping && rx_full;
  assign busy     = (state != SQ_IDLE);
  assign complete = (state == SQ_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      burst_left <= '0;
      skip_left  <= '0;
      lim_q      <= 1'b0;
      txd_q      <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          burst_left <= burst_len;
          skip_left  <= skip_mode ? skip_len : '0;
          lim_q      <= (burst_len != '0);
          state      <= SQ_FETCH;
        end
        SQ_FETCH: if (tx_empty) begin
          state <= SQ_FINISH;
        end else begin
          txd_q <= tx_data;
          state <= SQ_ISSUE;
        end
        SQ_ISSUE: state <= SQ_WAIT;
        SQ_WAIT: if (sh_done) begin
          skip_left <= count_down(skip_left);
          if (lim_q) burst_left <= count_down(burst_left);
          state <= last_xchg ? SQ_FINISH : SQ_FETCH;
        end
        SQ_FINISH: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        outstanding <= 1'b0;
    else if (sh_start) outstanding <= 1'b1;
    else if (sh_done)  outstanding <= 1'b0;
  end

  // R2: only one exchange in flight at the shift engine
  assert_single_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> !outstanding);

  // R2: the outgoing byte holds steady while the engine works
  assert_txd_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WAIT && !sh_done) |=> $stable(sh_txd));

  // R4: every discarded leading reply consumes one unit of the skip count
  assert_skip_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_done && skipping) |=> (skip_left == $past(skip_left) - ONE));

  // R5: the final counted exchange leads straight to completion
  assert_burst_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_done && last_xchg) |=> complete);

  // R6: a dry transmit queue at fetch time ends the burst
  assert_empty_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_dry |=> complete);

  // R9: completion is a single-cycle pulse followed by idle
  assert_complete_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (!complete && !busy));

  // R9: an accepted start makes the block busy
  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R8: a drop never coincides with a store
  assert_drop_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_drop && rx_push));

endmodule

// File: rtl/spi_burst_sequencer.sv
module spi_burst_sequencer
  import burstseq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_wdata,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_rd,
  output logic [BYTE_W-1:0] rx_rdata,
  output logic              rx_empty,
  output logic              rx_full,
  input  logic              start,
  input  logic              skip_mode,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  skip_len,
  output logic              sh_start,
  output logic [BYTE_W-1:0] sh_txd,
  input  logic              sh_done,
  input  logic [BYTE_W-1:0] sh_rxd,
  output logic              rx_drop,
  output logic              busy,
  output logic              complete
);
  logic              tx_pop;
  logic [BYTE_W-1:0] tx_head;
  logic              rx_push;
  logic [BYTE_W-1:0] rx_wdata;

  byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tx_wr),
    .wr_data (tx_wdata),
    .rd_en   (tx_pop),
    .rd_data (tx_head),
    .full    (tx_full),
    .empty   (tx_empty)
  );

  xchg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .skip_mode (skip_mode),
    .burst_len (burst_len),
    .skip_len  (skip_len),
    .tx_empty  (tx_empty),
    .tx_data   (tx_head),
    .tx_pop    (tx_pop),
    .sh_start  (sh_start),
    .sh_txd    (sh_txd),
    .sh_done   (sh_done),
    .sh_rxd    (sh_rxd),
    .rx_full   (rx_full),
    .rx_push   (rx_push),
    .rx_wdata  (rx_wdata),
    .rx_drop   (rx_drop),
    .busy      (busy),
    .complete  (complete)
  );

  byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rx_push),
    .wr_data (rx_wdata),
    .rd_en   (rx_rd),
    .rd_data (rx_rdata),
    .full    (rx_full),
    .empty   (rx_empty)
  );

endmodule

// File: tb/test_spi_burst_sequencer.sv
module test_spi_burst_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int CW         = 24;
  localparam logic [7:0] RX_XOR = 8'h3C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_wr = 1'b0;
  logic [7:0]    tx_wdata = '0;
  logic          tx_full, tx_empty;
  logic          rx_rd = 1'b0;
  logic [7:0]    rx_rdata;
  logic          rx_empty, rx_full;
  logic          start = 1'b0;
  logic          skip_mode = 1'b0;
  logic [CW-1:0] burst_len = '0;
  logic [CW-1:0] skip_len = '0;
  logic          sh_start;
  logic [7:0]    sh_txd;
  logic          sh_done = 1'b0;
  logic [7:0]    sh_rxd = '0;
  logic          rx_drop, busy, complete;

  spi_burst_sequencer #(.FIFO_DEPTH(DEPTH), .CNT_W(CW)) i_spi_burst_sequencer (
    .clk(clk), .rst_n(rst_n),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_empty(rx_empty), .rx_full(rx_full),
    .start(start), .skip_mode(skip_mode), .burst_len(burst_len), .skip_len(skip_len),
    .sh_start(sh_start), .sh_txd(sh_txd), .sh_done(sh_done), .sh_rxd(sh_rxd),
    .rx_drop(rx_drop), .busy(busy), .complete(complete)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int n_ex = 0, n_drop = 0, n_cmpl = 0;
  bit drain = 1'b1;
  int held = 0;
  bit finished = 1'b0;
  logic [7:0] txm[$];
  logic [7:0] sent_exp[$];
  logic [7:0] rx_exp[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // shift-engine model: latency 1..3 cycles, reply = sent ^ RX_XOR
  initial begin
    forever begin
      @(negedge clk);
      if (sh_start) begin
        logic [7:0] b;
        int lat;
        b = sh_txd;
        if (sent_exp.size() == 0) check(1'b0, "R2 unexpected exchange", b, -1);
        else begin
          logic [7:0] e;
          e = sent_exp.pop_front();
          check(b == e, "R2 transmit order", b, e);
        end
        lat = 1 + (n_ex % 3);
        n_ex++;
        repeat (lat) @(negedge clk);
        sh_done = 1'b1;
        sh_rxd  = b ^ RX_XOR;
        @(negedge clk);
        sh_done = 1'b0;
      end
    end
  end

  // monitor: drains and scores the receive queue, counts pulses
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rx_drop) n_drop++;
      if (complete) n_cmpl++;
      if (drain && !rx_empty) begin
        if (rx_exp.size() == 0) check(1'b0, "R3/R4 unexpected receive byte", rx_rdata, -1);
        else begin
          logic [7:0] e;
          e = rx_exp.pop_front();
          check(rx_rdata == e, "R3/R4 receive byte", rx_rdata, e);
        end
        rx_rd = 1'b1;
      end else begin
        rx_rd = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    summary();
  end

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    tx_wr = 1'b1;
    tx_wdata = b;
    if (txm.size() < DEPTH) txm.push_back(b);
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  // driver: forms expectations, then starts one burst and waits for its end
  task automatic run_burst(input bit mode, input int blen, input int slen,
                           input string req);
    int n, sk, ex0, c0, d0, dexp;
    n = txm.size();
    if (blen != 0 && blen < n) n = blen;
    sk = mode ? slen : 0;
    dexp = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = txm.pop_front();
      sent_exp.push_back(b);
      if (sk > 0) sk--;
      else if (!drain && held >= DEPTH) dexp++;
      else begin
        rx_exp.push_back(b ^ RX_XOR);
        if (!drain) held++;
      end
    end
    ex0 = n_ex; c0 = n_cmpl; d0 = n_drop;
    @(negedge clk);
    skip_mode = mode;
    burst_len = CW'(blen);
    skip_len  = CW'(slen);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #2;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    while (n_cmpl == c0) @(negedge clk);
    @(negedge clk);
    #2;
    check(!busy && !complete, "R9 idle after single complete pulse", busy, 0);
    check(n_ex - ex0 == n, req, n_ex - ex0, n);
    check(n_drop - d0 == dexp, "R8 drop pulses", n_drop - d0, dexp);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    check(!busy && !complete, "R1 busy/complete at reset", busy, 0);
    check(tx_empty && rx_empty, "R1 queues empty at reset", {tx_empty, rx_empty}, 3);
    check(!tx_full && !rx_full, "R1 queues not full at reset", {tx_full, rx_full}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 / R7: plain burst, no limit
    for (int i = 0; i < 5; i++) push_tx(8'h10 + 8'(i));
    run_burst(1'b0, 0, 0, "R7 unlimited burst exchange count");
    check(tx_empty, "R7 transmit queue drained", tx_empty, 1);
    check(rx_exp.size() == 0, "R3 all bytes delivered", rx_exp.size(), 0);

    // R4: skip two leading replies
    for (int i = 0; i < 6; i++) push_tx(8'hA0 + 8'(i));
    run_burst(1'b1, 0, 2, "R4 exchange count with skip");
    check(rx_exp.size() == 0, "R4 stored bytes delivered", rx_exp.size(), 0);

    // R4: skip longer than burst drops every reply
    for (int i = 0; i < 3; i++) push_tx(8'h55 + 8'(i));
    run_burst(1'b1, 0, 10, "R4 long skip exchange count");
    check(rx_empty, "R4 nothing stored for long skip", rx_empty, 1);

    // R5: limit ends the burst with bytes left over
    for (int i = 0; i < 6; i++) push_tx(8'hC0 + 8'(i));
    run_burst(1'b0, 3, 0, "R5 limited exchange count");
    check(!tx_empty, "R5 leftover bytes remain", tx_empty, 0);
    run_burst(1'b0, 0, 0, "R5 leftover bytes sent next");
    check(tx_empty, "R5 leftovers drained", tx_empty, 1);

    // R6: start on an empty transmit queue
    run_burst(1'b0, 4, 0, "R6 empty start exchange count");

    // R8: receive overflow with the drain stopped
    drain = 1'b0;
    held = 0;
    for (int i = 0; i < 6; i++) push_tx(8'h20 + 8'(i));
    run_burst(1'b0, 0, 0, "R8 first fill exchange count");
    for (int i = 0; i < 4; i++) push_tx(8'h30 + 8'(i));
    run_burst(1'b0, 0, 0, "R8 overflow exchange count");
    check(rx_full, "R8 receive full held", rx_full, 1);
    drain = 1'b1;
    held = 0;
    repeat (24) @(negedge clk);
    check(rx_exp.size() == 0 && rx_empty, "R8 kept bytes delivered", rx_exp.size(), 0);

    // R11: writes beyond capacity are ignored
    for (int i = 0; i < DEPTH + 2; i++) push_tx(8'h70 + 8'(i));
    check(tx_full, "R11 transmit full", tx_full, 1);
    run_burst(1'b0, 0, 0, "R11 only queued bytes sent");
    check(rx_exp.size() == 0, "R11 delivered bytes", rx_exp.size(), 0);

    // R9 / R10: start while busy, settings changed mid-burst
    begin
      int ex0, c0;
      for (int i = 0; i < 4; i++) push_tx(8'hE0 + 8'(i));
      for (int i = 0; i < 2; i++) begin
        logic [7:0] b;
        b = txm.pop_front();
        sent_exp.push_back(b);
        rx_exp.push_back(b ^ RX_XOR);
      end
      ex0 = n_ex; c0 = n_cmpl;
      @(negedge clk);
      skip_mode = 1'b0; burst_len = CW'(2); skip_len = '0;
      start = 1'b1;
      @(negedge clk);
      skip_mode = 1'b1; burst_len = '0; skip_len = CW'(5);
      @(negedge clk);
      start = 1'b0;
      while (n_cmpl == c0) @(negedge clk);
      repeat (12) @(negedge clk);
      check(n_cmpl - c0 == 1, "R9 one completion for ignored start", n_cmpl - c0, 1);
      check(n_ex - ex0 == 2, "R10 captured limit used", n_ex - ex0, 2);
      check(rx_exp.size() == 0, "R10 captured skip mode used", rx_exp.size(), 0);
      run_burst(1'b0, 0, 0, "R5 remaining bytes after R10 burst");
    end

    check(sent_exp.size() == 0, "R2 all expected exchanges seen", sent_exp.size(), 0);
    summary();
  end

endmodule